// File: doc/BRIEF.md
# Reservation Station with Broadcast Tag Wakeup

This block holds a small pool of waiting operations for one class of functional unit in a dynamically scheduled core. When an operation is issued, each of its two sources is either copied as a value or replaced by the tag of the station entry that will produce it. The block keeps a per-register table that records which entry will write each architectural register last. That table performs the renaming that removes write-after-read and write-after-write stalls.

Waiting entries watch a result broadcast bus. Each entry compares its pending source tags with the broadcast tag and latches the value when they match. An entry whose sources are all present asks to dispatch. The lowest-numbered ready entry is sent to the unit. The entry stays reserved until its own result is broadcast, and is then released.

A broadcast also produces a register-file write. That write is issued only when the broadcast tag is still the recorded producer of the register.

Top module: `rs_pool`

## Requirements
- R1: `iss_ready_o` is low when every entry is occupied, and an issue attempt in that state is discarded. `iss_ready_o` returns high in the cycle after a broadcast releases an entry.
- R2: Tag 0 means "value present", and entry i carries tag i+1. At issue, a source whose register has status tag 0 takes the value supplied on `rf_a_data_i` or `rf_b_data_i`. Any other source records the register's status tag.
- R3: A held entry whose pending source tag equals a valid broadcast tag latches the broadcast data for that source.
- R4: An entry is never dispatched while any of its sources is still pending. Its dispatched operand values are the captured ones.
- R5: When several entries are ready in the same cycle, the entry with the lowest index (lowest tag) is dispatched first.
- R6: An entry completed by a broadcast becomes dispatchable in the following cycle, not the broadcast cycle. A dispatched entry is released by the broadcast of its own tag.
- R7: A broadcast raises `rf_we_o` with the register number and data only for the register whose status tag equals the broadcast tag. A register re-targeted by a later issue is not written by the earlier producer.
- R8: A source whose producer tag is being broadcast in the issue cycle is captured straight from the bus as a present value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Operation code |
| iss_dst_i | input | log2(N_REG) | Destination register |
| iss_src_a_i | input | log2(N_REG) | Source A register |
| iss_src_b_i | input | log2(N_REG) | Source B register |
| rf_a_data_i | input | DATA_W | Register-file value of source A |
| rf_b_data_i | input | DATA_W | Register-file value of source B |
| iss_ready_o | output | 1 | A free entry exists |
| disp_valid_o | output | 1 | A ready entry is offered |
| disp_ready_i | input | 1 | Unit accepts the offered entry |
| disp_op_o | output | OP_W | Dispatched operation |
| disp_a_o | output | DATA_W | Dispatched operand A |
| disp_b_o | output | DATA_W | Dispatched operand B |
| disp_tag_o | output | log2(N_ENT+1) | Tag of the dispatched entry |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | log2(N_ENT+1) | Broadcast producer tag |
| bc_data_i | input | DATA_W | Broadcast value |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | log2(N_REG) | Register-file write address |
| rf_wdata_o | output | DATA_W | Register-file write data |

## Verification
The pool is filled with a chain of dependent operations, an independent one, and a write-after-write pair on one register. Two entries that become ready together show the lowest-index order. The pair shows that the older producer's broadcast is suppressed at the register file while the newer one writes. One broadcast is made in the same cycle as an issue that needs it, which separates bus capture at issue from later wakeup. Broadcast cycles are also checked for an absent dispatch, which shows that readiness lags capture by one cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_HELD = 2'd1,
    E_RUN  = 2'd2
  } ent_st_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_stat.sv
module rs_stat #(
  parameter int N_REG = 8,
  parameter int TAG_W = 3,
  localparam int REG_W = $clog2(N_REG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic [REG_W-1:0] rd_a_i,
  input  logic [REG_W-1:0] rd_b_i,
  output logic [TAG_W-1:0] tag_a_o,
  output logic [TAG_W-1:0] tag_b_o,
  input  logic             bc_valid_i,
  input  logic [TAG_W-1:0] bc_tag_i,
  output logic             hit_o,
  output logic [REG_W-1:0] hit_reg_o
);
  logic [TAG_W-1:0] stat_q [N_REG];
  logic [N_REG-1:0] hit;

  assign tag_a_o = stat_q[rd_a_i];
  assign tag_b_o = stat_q[rd_b_i];

  always_comb begin
    hit_reg_o = '0;
    for (int r = 0; r < N_REG; r++) begin
      hit[r] = bc_valid_i && (stat_q[r] != '0) && (stat_q[r] == bc_tag_i);
      if (hit[r]) hit_reg_o = REG_W'(r);
    end
  end
  assign hit_o = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_REG; r++) stat_q[r] <= '0;
    end else begin
      for (int r = 0; r < N_REG; r++) begin
        if (set_i && set_reg_i == REG_W'(r)) stat_q[r] <= set_tag_i;
        else if (hit[r])                     stat_q[r] <= '0;
      end
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit) <= 1); // R7
  AST_LATEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_q[$past(set_reg_i)] == $past(set_tag_i)); // R7
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int MY_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] va_i,
  input  logic [TAG_W-1:0]  qa_i,
  input  logic [DATA_W-1:0] vb_i,
  input  logic [TAG_W-1:0]  qb_i,
  input  logic              grant_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              free_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] va_o,
  output logic [DATA_W-1:0] vb_o
);
  ent_st_e           st_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] va_q, vb_q;
  logic [TAG_W-1:0]  qa_q, qb_q;

  assign free_o  = (st_q == E_IDLE);
  assign ready_o = (st_q == E_HELD) && (qa_q == '0) && (qb_q == '0);
  assign op_o    = op_q;
  assign va_o    = va_q;
  assign vb_o    = vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE;
      op_q <= '0;
      va_q <= '0;
      vb_q <= '0;
      qa_q <= '0;
      qb_q <= '0;
    end else if (alloc_i) begin
      st_q <= E_HELD;
      op_q <= op_i;
      va_q <= va_i;
      qa_q <= qa_i;
      vb_q <= vb_i;
      qb_q <= qb_i;
    end else begin
      if (st_q == E_HELD) begin
        if (qa_q != '0 && bc_valid_i && bc_tag_i == qa_q) begin
          va_q <= bc_data_i;
          qa_q <= '0;
        end
        if (qb_q != '0 && bc_valid_i && bc_tag_i == qb_q) begin
          vb_q <= bc_data_i;
          qb_q <= '0;
        end
        if (grant_i) st_q <= E_RUN;
      end else if (st_q == E_RUN) begin
        if (bc_valid_i && bc_tag_i == TAG_W'(MY_TAG)) st_q <= E_IDLE;
      end
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> st_q == E_IDLE); // R1
  AST_WAKE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_HELD && qa_q != '0 && bc_valid_i && bc_tag_i == qa_q && !alloc_i)
      |=> (qa_q == '0 && va_q == $past(bc_data_i))); // R3
  AST_GRANT_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (st_q == E_HELD && qa_q == '0 && qb_q == '0)); // R4
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_RUN && bc_valid_i && bc_tag_i == TAG_W'(MY_TAG) && !alloc_i)
      |=> st_q == E_IDLE); // R6
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N_ENT  = 4,
  parameter int N_REG  = 8,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  localparam int TAG_W = $clog2(N_ENT + 1),
  localparam int REG_W = $clog2(N_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  input  logic [REG_W-1:0]  iss_src_a_i,
  input  logic [REG_W-1:0]  iss_src_b_i,
  input  logic [DATA_W-1:0] rf_a_data_i,
  input  logic [DATA_W-1:0] rf_b_data_i,
  output logic              iss_ready_o,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o
);
  logic [N_ENT-1:0] free_v, ready_v, alloc_gnt, disp_gnt;
  logic [OP_W-1:0]   e_op [N_ENT];
  logic [DATA_W-1:0] e_va [N_ENT];
  logic [DATA_W-1:0] e_vb [N_ENT];
  logic              iss_fire;
  logic [TAG_W-1:0]  new_tag, tag_a, tag_b, qa, qb;
  logic [DATA_W-1:0] va, vb;

  assign iss_ready_o = |free_v;
  assign iss_fire    = iss_valid_i && iss_ready_o;

  rs_pick #(.N(N_ENT)) u_alloc_pick (.req_i(free_v),  .gnt_o(alloc_gnt));
  rs_pick #(.N(N_ENT)) u_disp_pick  (.req_i(ready_v), .gnt_o(disp_gnt));

  rs_stat #(.N_REG(N_REG), .TAG_W(TAG_W)) u_stat (
    .clk_i, .rst_ni,
    .set_i(iss_fire), .set_reg_i(iss_dst_i), .set_tag_i(new_tag),
    .rd_a_i(iss_src_a_i), .rd_b_i(iss_src_b_i),
    .tag_a_o(tag_a), .tag_b_o(tag_b),
    .bc_valid_i, .bc_tag_i,
    .hit_o(rf_we_o), .hit_reg_o(rf_waddr_o)
  );
  assign rf_wdata_o = bc_data_i;

  always_comb begin
    new_tag = '0;
    for (int i = 0; i < N_ENT; i++)
      if (alloc_gnt[i]) new_tag = TAG_W'(i + 1);
  end

  // source resolution: register file, same-cycle broadcast, or pending tag
  always_comb begin
    if (tag_a == '0)                              begin qa = '0;    va = rf_a_data_i; end
    else if (bc_valid_i && bc_tag_i == tag_a)     begin qa = '0;    va = bc_data_i;   end
    else                                          begin qa = tag_a; va = '0;          end
    if (tag_b == '0)                              begin qb = '0;    vb = rf_b_data_i; end
    else if (bc_valid_i && bc_tag_i == tag_b)     begin qb = '0;    vb = bc_data_i;   end
    else                                          begin qb = tag_b; vb = '0;          end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rs_entry #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(g + 1)) u_ent (
      .clk_i, .rst_ni,
      .alloc_i(iss_fire && alloc_gnt[g]),
      .op_i(iss_op_i), .va_i(va), .qa_i(qa), .vb_i(vb), .qb_i(qb),
      .grant_i(disp_gnt[g] && disp_ready_i),
      .bc_valid_i, .bc_tag_i, .bc_data_i,
      .free_o(free_v[g]), .ready_o(ready_v[g]),
      .op_o(e_op[g]), .va_o(e_va[g]), .vb_o(e_vb[g])
    );
  end

  assign disp_valid_o = |ready_v;

  always_comb begin
    disp_op_o  = '0;
    disp_a_o   = '0;
    disp_b_o   = '0;
    disp_tag_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (disp_gnt[i]) begin
        disp_op_o  = e_op[i];
        disp_a_o   = e_va[i];
        disp_b_o   = e_vb[i];
        disp_tag_o = TAG_W'(i + 1);
      end
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iss_ready_o && !bc_valid_i) |=> !iss_ready_o); // R1
  AST_DISP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_gnt)); // R5
endmodule

// File: tb/rs_pool_bench.sv
module rs_pool_bench;
  localparam int N_ENT = 4, N_REG = 8, DATA_W = 16, OP_W = 4;
  localparam int TAG_W = $clog2(N_ENT + 1), REG_W = $clog2(N_REG);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic iss_valid = 0, disp_ready = 0, bc_valid = 0;
  logic [OP_W-1:0] iss_op = '0;
  logic [REG_W-1:0] iss_dst = '0, iss_sa = '0, iss_sb = '0;
  logic [DATA_W-1:0] rf_a = '0, rf_b = '0, bc_data = '0;
  logic [TAG_W-1:0] bc_tag = '0;
  logic iss_ready, disp_valid, rf_we;
  logic [OP_W-1:0] disp_op;
  logic [DATA_W-1:0] disp_a, disp_b, rf_wdata;
  logic [TAG_W-1:0] disp_tag;
  logic [REG_W-1:0] rf_waddr;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [63:0] exp_q [$];

  always #2 clk = ~clk;

  rs_pool #(.N_ENT(N_ENT), .N_REG(N_REG), .DATA_W(DATA_W), .OP_W(OP_W)) u_rs_pool (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op), .iss_dst_i(iss_dst),
    .iss_src_a_i(iss_sa), .iss_src_b_i(iss_sb),
    .rf_a_data_i(rf_a), .rf_b_data_i(rf_b), .iss_ready_o(iss_ready),
    .disp_valid_o(disp_valid), .disp_ready_i(disp_ready),
    .disp_op_o(disp_op), .disp_a_o(disp_a), .disp_b_o(disp_b), .disp_tag_o(disp_tag),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_disp(string req, int op, int a, int b, int tag);
    exp_q.push_back({OP_W'(op), DATA_W'(a), DATA_W'(b), TAG_W'(tag)});
  endtask

  // monitor: each accepted dispatch is compared with the oldest expected item (R4, R5)
  always @(negedge clk) begin
    if (rst_ni && disp_valid && disp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected dispatch", {disp_op, disp_a, disp_b, disp_tag}, 64'hdead);
      end else begin
        chk("R4 dispatch contents", {disp_op, disp_a, disp_b, disp_tag}, exp_q.pop_front());
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(int op, int dst, int sa, int sb, int va, int vb);
    iss_valid = 1; iss_op = OP_W'(op); iss_dst = REG_W'(dst);
    iss_sa = REG_W'(sa); iss_sb = REG_W'(sb); rf_a = DATA_W'(va); rf_b = DATA_W'(vb);
    step();
    iss_valid = 0;
  endtask

  task automatic bcast_drive(int tag, int data);
    bc_valid = 1; bc_tag = TAG_W'(tag); bc_data = DATA_W'(data);
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk("R1 reset iss_ready", iss_ready, 1);
    chk("R4 reset disp_valid", disp_valid, 0);
    chk("R7 reset rf_we", rf_we, 0);
    step();

    // fill: A tag1, B tag2 waits on r1, C tag3 re-targets r1 and waits on r4, D tag4
    issue(1, 1, 2, 3, 10, 20);   // R2 values copied
    issue(2, 4, 1, 2, 0, 10);    // R2 tag recorded
    issue(3, 1, 4, 4, 0, 0);
    issue(4, 5, 6, 7, 60, 70);
    @(negedge clk);
    chk("R1 full stalls issue", iss_ready, 0);
    step();
    issue(9, 7, 0, 0, 99, 99);   // discarded while full (R1)

    // R5: tags 1 and 4 both ready, lowest first
    expect_disp("R5", 1, 10, 20, 1);
    expect_disp("R5", 4, 60, 70, 4);
    disp_ready = 1;
    repeat (3) step();

    // broadcast tag1: r1 now owned by tag3, so no write (R7); B wakes (R3)
    expect_disp("R3", 2, 111, 10, 2);
    bcast_drive(1, 111);
    @(negedge clk);
    chk("R7 stale producer suppressed", rf_we, 0);
    chk("R6 no dispatch in broadcast cycle", disp_valid, 0);
    step();
    bc_valid = 0;
    @(negedge clk);
    chk("R1 issue resumes after release", iss_ready, 1);
    step();

    // broadcast tag2 with same-cycle issue that needs it (R8); C wakes on both sources
    expect_disp("R3", 3, 222, 222, 3);
    bcast_drive(2, 222);
    iss_valid = 1; iss_op = 5; iss_dst = 6; iss_sa = 4; iss_sb = 1; rf_a = 16'h0bad; rf_b = 16'h0bad;
    @(negedge clk);
    chk("R7 current producer writes", {rf_we, rf_waddr, rf_wdata}, {1'b1, 3'd4, 16'd222});
    chk("R6 completion not yet dispatchable", disp_valid, 0);
    step();
    bc_valid = 0; iss_valid = 0;
    @(negedge clk);
    chk("R6 ready one cycle after capture", disp_valid, 1);
    step();

    // broadcast tag3: latest producer of r1 writes; new entry (tag1) completes
    expect_disp("R8", 5, 222, 333, 1);
    bcast_drive(3, 333);
    @(negedge clk);
    chk("R7 latest producer of r1", {rf_we, rf_waddr, rf_wdata}, {1'b1, 3'd1, 16'd333});
    step();
    bc_valid = 0;
    repeat (2) step();

    // release remaining entries
    bcast_drive(4, 444);
    @(negedge clk);
    chk("R7 r5 written by tag4", {rf_we, rf_waddr, rf_wdata}, {1'b1, 3'd5, 16'd444});
    step();
    bcast_drive(1, 555);
    @(negedge clk);
    chk("R7 r6 written by tag1", {rf_we, rf_waddr, rf_wdata}, {1'b1, 3'd6, 16'd555});
    step();
    bc_valid = 0;
    repeat (2) step();
    @(negedge clk);
    chk("R6 all entries released", iss_ready, 1);
    chk("R4 no leftover dispatch", disp_valid, 0);
    chk("R5 expected queue drained", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule